// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one counting channel of a legacy-style interval timer. The channel advances by one on every clock where `tick_en` is high, and `tick_en` is driven at the timer rate. A load strobe captures a 3-bit mode and a 16-bit initial count. The channel output then follows the waveform that the mode selects, based on the ticks that have elapsed since the last start point. A gate input can restart timing in the modes that retrigger. The channel also reports how many ticks remain in its present period, so the value can be read back through the surrounding register file.

Internally, a small state machine tracks where the channel is in its period:

- `ST_RUN`: a one-shot is counting.
- `ST_HIT`: the single terminal tick of the strobe modes.
- `ST_DONE`: a one-shot has finished and the position is frozen.
- `ST_PFIRST`: a periodic mode is in its first period.
- `ST_PLOOP`: a periodic mode has wrapped at least once.

The transitions are:

- Start (load or gate retrigger) goes to `ST_PFIRST` for modes 2, 3, 6 and 7, and to `ST_RUN` for the others.
- `ST_RUN` goes to `ST_HIT` (modes 4 and 5) or to `ST_DONE` (modes 0 and 1) on the tick that reaches the count.
- `ST_HIT` goes to `ST_DONE` on the next tick.
- `ST_PFIRST` goes to `ST_PLOOP` on the tick that wraps.
- `ST_DONE` and `ST_PLOOP` hold.

Counting is binary only.

Top module: `pit_channel`

## Requirements
- R1: On a clock edge with `load_i` high, `mode_i` and `count_i` are captured, and the elapsed tick count becomes zero. This takes priority over a gate edge and over `tick_en` in the same cycle, so the next `count_o` equals the loaded count.
- R2: A loaded count of 0 acts as a period of 65536 ticks. In that case `count_o` reads 0 at the start point.
- R3: Mode 0: `out_o` is low while the elapsed ticks are below the count. It is high from the tick that reaches the count onward, until the next load.
- R4: Mode 1: `out_o` is high while the elapsed ticks are below the count. It is low afterwards, until a restart.
- R5: Mode 2: `out_o` is high for exactly the ticks where the elapsed count is a nonzero multiple of the count. It is low otherwise.
- R6: Mode 3: within each period of length N, `out_o` is high for the first floor((N+1)/2) ticks and low for the rest.
- R7: Modes 4 and 5: `out_o` is high only on the tick where the elapsed count equals the count. It is low before and after.
- R8: The elapsed count advances only on clocks with `tick_en` high. `count_o` gives N minus the position within the present period, modulo 65536, and reads 0 once a one-shot mode has finished.
- R9: In modes 1, 2, 3, 5, 6 and 7, a rising edge on `gate_i` (compared with its value at the previous clock) restarts timing from zero. The restart wins over a tick in the same cycle.
- R10: In modes 0 and 4, a rising gate edge has no effect. A falling gate edge has no effect in any mode.
- R11: Reset selects mode 3 with a count of 65536 and a zero elapsed count. The stored gate level resets high, except when `CHAN_IDX` is 2, where it resets low. A gate held high at reset release therefore retriggers only channel 2.
- R12: Mode codes 6 and 7 behave as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer-rate enable; one tick per high clock |
| load_i | input | 1 | Strobe that captures mode and count and starts timing |
| mode_i | input | 3 | Counting mode code 0..7 |
| count_i | input | CNT_W | Initial count; 0 means 2^CNT_W |
| gate_i | input | 1 | Gate level; rising edges retrigger some modes |
| out_o | output | 1 | Channel output bit |
| count_o | output | CNT_W | Ticks remaining in the present period |

## Verification
The checker watches several rules on every cycle:

- A load and a qualifying gate edge each present the full count on the next cycle.
- Nothing moves when there is no tick, no load and no retrigger.
- An ignored gate edge leaves both outputs untouched.
- Mode 0 stays high once it is high, and mode 1 stays low once it is low.
- The strobe and rate pulses last a single tick.

Only the bench's scenarios can show the exact waveform positions. These are the tick where each mode switches, the half-period split of mode 3 for odd and even counts, the 65536 case, and the per-channel gate reset level. The bench checks them against arithmetic on the elapsed tick count.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_HIT    = 3'd1,
        ST_DONE   = 3'd2,
        ST_PFIRST = 3'd3,
        ST_PLOOP  = 3'd4
    } pit_state_e;

    typedef enum logic [2:0] {
        CLS_ARM    = 3'd0,   // low until terminal, then high
        CLS_SHOT   = 3'd1,   // high until terminal, then low
        CLS_RATE   = 3'd2,   // one-tick pulse each wrap
        CLS_SQUARE = 3'd3,   // half high, half low
        CLS_STROBE = 3'd4    // single tick at terminal
    } pit_cls_e;

    localparam logic [2:0] RESET_MODE = 3'd3;

    function automatic pit_cls_e class_of(input logic [2:0] m);
        pit_cls_e c;
        unique case (m)
            3'd0:        c = CLS_ARM;
            3'd1:        c = CLS_SHOT;
            3'd2, 3'd6:  c = CLS_RATE;
            3'd3, 3'd7:  c = CLS_SQUARE;
            default:     c = CLS_STROBE;
        endcase
        return c;
    endfunction

    function automatic logic is_periodic(input pit_cls_e c);
        return (c == CLS_RATE) || (c == CLS_SQUARE);
    endfunction

    function automatic logic gate_retrig(input logic [2:0] m);
        return !((m == 3'd0) || (m == 3'd4));
    endfunction

endpackage

// File: rtl/pit_cfg.sv
module pit_cfg #(
    parameter int CNT_W = 16,
    localparam int PW = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [2:0]       mode_q,
    output logic [CNT_W-1:0] len_q,
    output logic [PW-1:0]    period
);
    import pit_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= RESET_MODE;
            len_q  <= '0;
        end else if (load_i) begin
            mode_q <= mode_i;
            len_q  <= count_i;
        end
    end

    always_comb begin
        if (len_q == '0) begin
            period = {1'b1, {CNT_W{1'b0}}};
        end else begin
            period = {1'b0, len_q};
        end
    end
endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge #(
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic rise
);
    logic gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= RST_LEVEL;
        end else begin
            gate_q <= gate_i;
        end
    end

    assign rise = gate_i & ~gate_q;
endmodule

// File: rtl/pit_fsm.sv
module pit_fsm #(
    parameter int PW = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                restart,
    input  pit_pkg::pit_cls_e   start_cls,
    input  pit_pkg::pit_cls_e   cls,
    input  logic [PW-1:0]       period,
    output pit_pkg::pit_state_e state_o,
    output logic [PW-1:0]       pos_o
);
    import pit_pkg::*;

    pit_state_e    st_q, st_n;
    logic [PW-1:0] pos_q, pos_n;
    logic [PW-1:0] pos_inc;
    logic          at_end;

    assign pos_inc = pos_q + {{(PW-1){1'b0}}, 1'b1};
    assign at_end  = (pos_inc == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_PFIRST;
            pos_q <= '0;
        end else begin
            st_q  <= st_n;
            pos_q <= pos_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        pos_n = pos_q;
        if (restart) begin
            st_n  = is_periodic(start_cls) ? ST_PFIRST : ST_RUN;
            pos_n = '0;
        end else if (tick_en) begin
            unique case (st_q)
                ST_RUN: begin
                    pos_n = pos_inc;
                    if (at_end) begin
                        st_n = (cls == CLS_STROBE) ? ST_HIT : ST_DONE;
                    end
                end
                ST_HIT: begin
                    st_n = ST_DONE;
                end
                ST_DONE: begin
                    st_n = ST_DONE;
                end
                ST_PFIRST, ST_PLOOP: begin
                    if (at_end) begin
                        pos_n = '0;
                        st_n  = ST_PLOOP;
                    end else begin
                        pos_n = pos_inc;
                    end
                end
                default: begin
                    st_n  = ST_DONE;
                end
            endcase
        end
    end

    assign state_o = st_q;
    assign pos_o   = pos_q;
endmodule

// File: rtl/pit_out.sv
module pit_out #(
    parameter int CNT_W = 16,
    localparam int PW = CNT_W + 1
) (
    input  pit_pkg::pit_state_e state,
    input  pit_pkg::pit_cls_e   cls,
    input  logic [PW-1:0]       pos,
    input  logic [PW-1:0]       period,
    output logic                out_o,
    output logic [CNT_W-1:0]    count_o
);
    import pit_pkg::*;

    logic [PW-1:0] half;
    logic [PW-1:0] remain;

    assign half   = (period + {{(PW-1){1'b0}}, 1'b1}) >> 1;
    assign remain = period - pos;

    always_comb begin
        unique case (cls)
            CLS_ARM:    out_o = (state == ST_DONE);
            CLS_SHOT:   out_o = (state == ST_RUN);
            CLS_RATE:   out_o = (state == ST_PLOOP) && (pos == '0);
            CLS_SQUARE: out_o = (pos < half);
            default:    out_o = (state == ST_HIT);
        endcase
    end

    always_comb begin
        unique case (state)
            ST_HIT, ST_DONE: count_o = '0;
            default:         count_o = remain[CNT_W-1:0];
        endcase
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
    parameter int CNT_W    = 16,
    parameter int CHAN_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             gate_i,
    output logic             out_o,
    output logic [CNT_W-1:0] count_o
);
    import pit_pkg::*;

    localparam int   PW        = CNT_W + 1;
    localparam logic GATE_INIT = (CHAN_IDX != 2);

    logic [2:0]       cfg_mode;
    logic [CNT_W-1:0] cfg_len;
    logic [PW-1:0]    period;
    logic             gate_rise;
    logic             restart;
    pit_cls_e         cls_q;
    pit_cls_e         start_cls;
    pit_state_e       state;
    logic [PW-1:0]    pos;

    pit_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .mode_i  (mode_i),
        .count_i (count_i),
        .mode_q  (cfg_mode),
        .len_q   (cfg_len),
        .period  (period)
    );

    pit_gate_edge #(.RST_LEVEL(GATE_INIT)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate_i),
        .rise   (gate_rise)
    );

    assign cls_q     = class_of(cfg_mode);
    assign start_cls = load_i ? class_of(mode_i) : cls_q;
    assign restart   = load_i | (gate_rise & gate_retrig(cfg_mode));

    pit_fsm #(.PW(PW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .restart   (restart),
        .start_cls (start_cls),
        .cls       (cls_q),
        .period    (period),
        .state_o   (state),
        .pos_o     (pos)
    );

    pit_out #(.CNT_W(CNT_W)) u_out (
        .state   (state),
        .cls     (cls_q),
        .pos     (pos),
        .period  (period),
        .out_o   (out_o),
        .count_o (count_o)
    );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
    parameter int CNT_W    = 16,
    parameter int CHAN_IDX = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             load_i,
    input logic [CNT_W-1:0] count_i,
    input logic             gate_i,
    input logic             out_o,
    input logic [CNT_W-1:0] count_o,
    input logic [2:0]       mode_q,
    input logic [CNT_W-1:0] len_q
);
    logic gprev;
    logic rise;
    logic can_retrig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gprev <= (CHAN_IDX != 2);
        end else begin
            gprev <= gate_i;
        end
    end

    assign rise       = gate_i && !gprev;
    assign can_retrig = (mode_q != 3'd0) && (mode_q != 3'd4);

    AST_LOAD_PRESENTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(count_i))); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_en && !(rise && can_retrig)) |=> ($stable(count_o) && $stable(out_o))); // R8

    AST_GATE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && rise && can_retrig) |=> (count_o == $past(len_q))); // R9

    AST_GATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_en && rise && !can_retrig) |=> ($stable(count_o) && $stable(out_o))); // R10

    AST_ARM_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd0 && out_o && !load_i) |=> out_o); // R3

    AST_SHOT_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd1 && !out_o && !load_i && !rise) |=> !out_o); // R4

    AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 3'd4 || mode_q == 3'd5) && out_o && tick_en && !load_i && !rise) |=> !out_o); // R7

    AST_RATE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 3'd2 || mode_q == 3'd6) && len_q != 1 && out_o && tick_en && !load_i && !rise)
        |=> !out_o); // R5
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W), .CHAN_IDX(CHAN_IDX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .load_i  (load_i),
    .count_i (count_i),
    .gate_i  (gate_i),
    .out_o   (out_o),
    .count_o (count_o),
    .mode_q  (cfg_mode),
    .len_q   (cfg_len)
);

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         load_i = 1'b0;
    logic [2:0]   mode_i = 3'd0;
    logic [W-1:0] count_i = '0;
    logic         gate_i = 1'b1;
    logic         out0, out2;
    logic [W-1:0] cnt0, cnt2;

    always #2.5 clk = ~clk;

    pit_channel #(.CNT_W(W), .CHAN_IDX(0)) i_pit_channel (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_i(load_i),
        .mode_i(mode_i), .count_i(count_i), .gate_i(gate_i),
        .out_o(out0), .count_o(cnt0)
    );

    pit_channel #(.CNT_W(W), .CHAN_IDX(2)) i_pit_channel_c2 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_i(load_i),
        .mode_i(mode_i), .count_i(count_i), .gate_i(gate_i),
        .out_o(out2), .count_o(cnt2)
    );

    int checks = 0;
    int errors = 0;
    int m_mode = 3;
    int m_len  = 65536;
    int m_d    = 0;
    bit m_gprev = 1'b1;
    bit done = 1'b0;

    function automatic bit ref_out(int m, int n, int d);
        int mm = (m == 6) ? 2 : (m == 7) ? 3 : m;
        case (mm)
            0:       return d >= n;
            1:       return d < n;
            2:       return (d % n == 0) && (d != 0);
            3:       return (d % n) < ((n + 1) / 2);
            default: return d == n;
        endcase
    endfunction

    function automatic int ref_cnt(int m, int n, int d);
        if (m == 2 || m == 3 || m == 6 || m == 7) return (n - (d % n)) & 16'hFFFF;
        if (d < n) return (n - d) & 16'hFFFF;
        return 0;
    endfunction

    function automatic string tag_of(int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4, 5: return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string tag);
        bit eo = ref_out(m_mode, m_len, m_d);
        int ec = ref_cnt(m_mode, m_len, m_d);
        checks++;
        if (out0 !== eo || int'(cnt0) != ec) begin
            errors++;
            $display("FAIL %s mode=%0d len=%0d d=%0d actual out=%0b cnt=%0d expected out=%0b cnt=%0d",
                     tag, m_mode, m_len, m_d, out0, cnt0, eo, ec);
        end
    endtask

    task automatic chk2(string tag, bit eo, int ec);
        checks++;
        if (out2 !== eo || int'(cnt2) != ec) begin
            errors++;
            $display("FAIL %s channel2 actual out=%0b cnt=%0d expected out=%0b cnt=%0d",
                     tag, out2, cnt2, eo, ec);
        end
    endtask

    // called right after a falling edge; returns after the next falling edge
    task automatic step(bit ld, int m, int c, bit te, bit g);
        bit rise;
        load_i  = ld;
        mode_i  = m[2:0];
        count_i = c[W-1:0];
        tick_en = te;
        gate_i  = g;
        @(negedge clk);
        rise = g && !m_gprev;
        m_gprev = g;
        if (ld) begin
            m_mode = m;
            m_len  = (c == 0) ? 65536 : c;
            m_d    = 0;
        end else if (rise && !(m_mode == 0 || m_mode == 4)) begin
            m_d = 0;
        end else if (te) begin
            m_d++;
        end
        load_i  = 1'b0;
        tick_en = 1'b0;
    endtask

    task automatic ticks(int k, string tag, bit each);
        for (int i = 0; i < k; i++) begin
            step(1'b0, m_mode, m_len, 1'b1, gate_i);
            if (each) chk(tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        gate_i  = 1'b1;
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset ch0");
        chk2("R11 reset ch2", 1'b1, 0);
        for (int i = 0; i < 3; i++) step(1'b0, 3, 0, 1'b1, 1'b1);
        chk("R11 R8 ch0 three ticks");
        chk2("R11 ch2 retriggered by gate", 1'b1, 65534);
        step(1'b0, 3, 0, 1'b0, 1'b1);
        chk("R8 no tick hold");

        // R2 R6: default 65536 square wave split
        ticks(32764, "R6", 1'b0);
        chk("R6 R2 last high tick");
        ticks(1, "R6 R2 first low tick", 1'b1);

        // sweep all modes over small counts
        for (int m = 0; m < 8; m++) begin
            for (int n = 1; n <= 6; n++) begin
                step(1'b1, m, n, 1'b0, 1'b1);
                chk("R1 load");
                ticks(2 * n + 3, tag_of(m), 1'b1);
            end
        end

        // gate retrigger in periodic mode 2
        step(1'b1, 2, 4, 1'b0, 1'b1);
        ticks(6, "R5", 1'b1);
        step(1'b0, 2, 4, 1'b0, 1'b0);
        chk("R10 falling edge ignored");
        step(1'b0, 2, 4, 1'b0, 1'b1);
        chk("R9 mode2 restart");
        ticks(5, "R9 mode2 after restart", 1'b1);

        // gate retrigger in one-shot modes 1 and 5
        step(1'b1, 1, 3, 1'b0, 1'b1);
        ticks(4, "R4", 1'b1);
        step(1'b0, 1, 3, 1'b0, 1'b0);
        step(1'b0, 1, 3, 1'b0, 1'b1);
        chk("R9 mode1 restart");
        ticks(4, "R9 mode1 after restart", 1'b1);
        step(1'b1, 5, 3, 1'b0, 1'b1);
        ticks(5, "R7", 1'b1);
        step(1'b0, 5, 3, 1'b0, 1'b0);
        step(1'b0, 5, 3, 1'b0, 1'b1);
        chk("R9 mode5 restart");
        ticks(4, "R9 mode5 after restart", 1'b1);

        // gate ignored in modes 0 and 4
        step(1'b1, 0, 5, 1'b0, 1'b1);
        ticks(2, "R3", 1'b0);
        step(1'b0, 0, 5, 1'b0, 1'b0);
        step(1'b0, 0, 5, 1'b0, 1'b1);
        chk("R10 mode0 gate ignored");
        ticks(3, "R10 mode0 continues", 1'b1);
        step(1'b1, 4, 5, 1'b0, 1'b1);
        ticks(2, "R7", 1'b0);
        step(1'b0, 4, 5, 1'b0, 1'b0);
        step(1'b0, 4, 5, 1'b0, 1'b1);
        chk("R10 mode4 gate ignored");
        ticks(4, "R10 mode4 continues", 1'b1);

        // priorities
        step(1'b1, 3, 8, 1'b0, 1'b1);
        ticks(3, "R6", 1'b0);
        step(1'b0, 3, 8, 1'b0, 1'b0);
        step(1'b0, 3, 8, 1'b1, 1'b1);
        chk("R9 restart beats tick");
        step(1'b0, 3, 8, 1'b1, 1'b0);
        step(1'b1, 2, 9, 1'b1, 1'b1);
        chk("R1 load beats restart and tick");

        // R2: zero count in mode 0
        step(1'b1, 0, 0, 1'b0, 1'b1);
        chk("R2 zero count load");
        ticks(65535, "R2", 1'b0);
        chk("R2 one tick before terminal");
        ticks(1, "R2 terminal reached", 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule